// File: doc/BRIEF.md
# Multi-Resolution Bus Trace Abstractor

This block watches a pipelined on-chip bus and converts the signals it sees into a single stream of trace records. Software picks a trace mode, and the mode can change while a capture is running. The mode sets two things. The first is which signals a record carries: everything (address, data and a packed control word), address and data with a three-bit encoded bus state in place of the control word, or only address and data. The second is how often a record is produced: on every clock, or only when one of the carried values differs from the value seen on the previous traced cycle.

All five modes write into the same output stream. Each record carries its mode tag and one presence flag per field, so a downstream decoder can rebuild the waveform across mode switches. The first record after a mode change, and the first record after tracing is enabled, always carries every field of its mode. This lets the decoder resynchronise. Compressing the fields and packing records into memory are handled by later stages.

Top module: `bus_trace_abstractor`

## Requirements
- R1: After reset, and until the first traced cycle has been registered, rec_valid is 0 and every record output is zero.
- R2: While trace_en is 0, no record is emitted. The stored previous values are discarded, so the first record after tracing resumes carries every field of its mode.
- R3: A record built from the bus inputs sampled at one clock edge appears on the outputs right after that edge. rec_mode equals the mode_sel value sampled at that edge. When rec_valid is 0, rec_mode is 0.
- R4: Mode 1 (all signals, cycle level) emits a record every traced cycle, with address, data and control present and state absent.
- R5: Mode 2 (all signals, transaction level) emits a record only when the address, data or control word differs from the previous traced cycle. Only the fields that differ are marked present.
- R6: Mode 3 (bus state, cycle level) emits a record every traced cycle, with address, data and state present and control absent.
- R7: Mode 4 (bus state, transaction level) emits a record only when the address, data or bus state differs from the previous traced cycle. Only the fields that differ are marked present.
- R8: Mode 5 (master operation, transaction level) carries only address and data. A cycle in which only control signals change produces no record.
- R9: Bus state codes are checked in this priority order. A non-OKAY response gives ERROR=4, RETRY=5 or SPLIT=6 (resp 1, 2, 3). Otherwise, ready low gives WAIT=3. Otherwise, trans IDLE (0) gives IDLE=0, BUSY (1) gives BUSY=1, and NONSEQ/SEQ (2, 3) give NORMAL=2.
- R10: On the first traced cycle after mode_sel changes, a record is emitted with every field of the new mode present, even if no bus value changed.
- R11: mode_sel values 0, 6 and 7 behave like trace_en low: no record is emitted and the history is cleared.
- R12: rec_ctrl packs {write, size[2:0], burst[2:0], trans[1:0], ready, resp[1:0]}, with write at bit 11 and resp at bits 1:0. A field that is not present reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_en | input | 1 | Tracing enable |
| mode_sel | input | 3 | Trace mode, 1 to 5 |
| bus_addr | input | ADDR_W | Observed bus address |
| bus_data | input | DATA_W | Observed bus data |
| bus_trans | input | 2 | Transfer type (0 idle, 1 busy, 2 nonseq, 3 seq) |
| bus_write | input | 1 | Transfer direction |
| bus_size | input | 3 | Transfer size |
| bus_burst | input | 3 | Burst type |
| bus_ready | input | 1 | Transfer ready |
| bus_resp | input | 2 | Slave response (0 OKAY) |
| rec_valid | output | 1 | Record valid this cycle |
| rec_mode | output | 3 | Mode tag of the record |
| rec_addr_vld | output | 1 | Address field present |
| rec_addr | output | ADDR_W | Address field |
| rec_data_vld | output | 1 | Data field present |
| rec_data | output | DATA_W | Data field |
| rec_ctrl_vld | output | 1 | Control field present |
| rec_ctrl | output | 12 | Packed control field |
| rec_state_vld | output | 1 | Bus state field present |
| rec_state | output | 3 | Encoded bus state |

## Verification
A corrupted history register appears as a spurious or missing record on the next traced cycle, and only in the transaction-level modes. The bench therefore repeats identical bus values and flips single fields to expose it within one cycle. A stale mode or sync flag shows up as a missing full record on the first cycle after a switch or re-enable. A wrong state-encoding priority shows up at once as a wrong rec_state code when a bad response coincides with ready low.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int MODE_W  = 3;
  localparam int STATE_W = 3;
  localparam int CTRL_W  = 12;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE   = 3'd0,
    ST_BUSY   = 3'd1,
    ST_NORMAL = 3'd2,
    ST_WAIT   = 3'd3,
    ST_ERROR  = 3'd4,
    ST_RETRY  = 3'd5,
    ST_SPLIT  = 3'd6
  } bus_state_e;

  function automatic logic mode_ok(input logic [MODE_W-1:0] m);
    return (m >= 3'd1) && (m <= 3'd5);
  endfunction
endpackage

// File: rtl/trc_state_encode.sv
module trc_state_encode
  import trc_pkg::*;
(
  input  logic [1:0]         trans,
  input  logic               ready,
  input  logic [1:0]         resp,
  output logic [STATE_W-1:0] state
);
  bus_state_e st;

  always_comb begin
    if (resp == 2'd1)      st = ST_ERROR;
    else if (resp == 2'd2) st = ST_RETRY;
    else if (resp == 2'd3) st = ST_SPLIT;
    else if (!ready)       st = ST_WAIT;
    else if (trans == 2'd0) st = ST_IDLE;
    else if (trans == 2'd1) st = ST_BUSY;
    else                   st = ST_NORMAL;
    state = st;
  end

  // R9: a non-OKAY response always outranks the wait and transfer codes
  always_comb begin
    if (resp != 2'd0) assert_resp_first_R9: assert (state >= 3'd4);
  end
endmodule

// File: rtl/trc_field_track.sv
module trc_field_track #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_en,
  input  logic [W-1:0] cur,
  output logic         changed
);
  logic [W-1:0] prev_q, prev_d;

  always_comb begin
    prev_d = hold_en ? cur : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign changed = (cur != prev_q);
endmodule

// File: rtl/trc_record_former.sv
module trc_record_former
  import trc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trace_en,
  input  logic [MODE_W-1:0]  mode_sel,
  input  logic [ADDR_W-1:0]  cur_addr,
  input  logic [DATA_W-1:0]  cur_data,
  input  logic [CTRL_W-1:0]  cur_ctrl,
  input  logic [STATE_W-1:0] cur_state,
  input  logic               chg_addr,
  input  logic               chg_data,
  input  logic               chg_ctrl,
  input  logic               chg_state,
  output logic               hold_en,
  output logic               rec_valid,
  output logic [MODE_W-1:0]  rec_mode,
  output logic               rec_addr_vld,
  output logic [ADDR_W-1:0]  rec_addr,
  output logic               rec_data_vld,
  output logic [DATA_W-1:0]  rec_data,
  output logic               rec_ctrl_vld,
  output logic [CTRL_W-1:0]  rec_ctrl,
  output logic               rec_state_vld,
  output logic [STATE_W-1:0] rec_state
);
  logic              active, force_full, cyc_lvl, sel_ctrl, sel_state;
  logic              synced_q, synced_d;
  logic [MODE_W-1:0] last_mode_q, last_mode_d;
  logic              pa, pd, pc, ps;
  logic              valid_q, valid_d, av_q, dv_q, cv_q, sv_q;
  logic [MODE_W-1:0]  mode_q, mode_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [DATA_W-1:0]  data_q, data_d;
  logic [CTRL_W-1:0]  ctrl_q, ctrl_d;
  logic [STATE_W-1:0] state_q, state_d;

  always_comb begin
    active      = trace_en && mode_ok(mode_sel);
    force_full  = !synced_q || (mode_sel != last_mode_q);
    cyc_lvl     = (mode_sel == 3'd1) || (mode_sel == 3'd3);
    sel_ctrl    = (mode_sel == 3'd1) || (mode_sel == 3'd2);
    sel_state   = (mode_sel == 3'd3) || (mode_sel == 3'd4);
    pa = active && (force_full || cyc_lvl || chg_addr);
    pd = active && (force_full || cyc_lvl || chg_data);
    pc = active && sel_ctrl  && (force_full || cyc_lvl || chg_ctrl);
    ps = active && sel_state && (force_full || cyc_lvl || chg_state);
    valid_d     = pa || pd || pc || ps;
    mode_d      = valid_d ? mode_sel : '0;
    addr_d      = pa ? cur_addr  : '0;
    data_d      = pd ? cur_data  : '0;
    ctrl_d      = pc ? cur_ctrl  : '0;
    state_d     = ps ? cur_state : '0;
    synced_d    = active;
    last_mode_d = active ? mode_sel : '0;
    hold_en     = active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced_q    <= 1'b0;
      last_mode_q <= '0;
      valid_q     <= 1'b0;
      av_q        <= 1'b0;
      dv_q        <= 1'b0;
      cv_q        <= 1'b0;
      sv_q        <= 1'b0;
      mode_q      <= '0;
      addr_q      <= '0;
      data_q      <= '0;
      ctrl_q      <= '0;
      state_q     <= '0;
    end else begin
      synced_q    <= synced_d;
      last_mode_q <= last_mode_d;
      valid_q     <= valid_d;
      av_q        <= pa;
      dv_q        <= pd;
      cv_q        <= pc;
      sv_q        <= ps;
      mode_q      <= mode_d;
      addr_q      <= addr_d;
      data_q      <= data_d;
      ctrl_q      <= ctrl_d;
      state_q     <= state_d;
    end
  end

  assign rec_valid     = valid_q;
  assign rec_mode      = mode_q;
  assign rec_addr_vld  = av_q;
  assign rec_addr      = addr_q;
  assign rec_data_vld  = dv_q;
  assign rec_data      = data_q;
  assign rec_ctrl_vld  = cv_q;
  assign rec_ctrl      = ctrl_q;
  assign rec_state_vld = sv_q;
  assign rec_state     = state_q;

  // R2 / R11: an untraced cycle yields no record
  assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(trace_en && mode_ok(mode_sel)) |=> !rec_valid);

  // R4 / R6: cycle-level modes never skip a cycle
  assert_cycle_every_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && (mode_sel == 3'd1 || mode_sel == 3'd3)) |=> rec_valid);

  // R3: records carry a legal mode tag
  assert_tag_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_mode >= 3'd1 && rec_mode <= 3'd5));

  // R12: control and state fields are never present together
  assert_ctrl_state_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(rec_ctrl_vld && rec_state_vld));

  // R10: first traced cycle of a mode gives a full record
  assert_full_on_switch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && mode_ok(mode_sel) && (!synced_q || mode_sel != last_mode_q))
      |=> (rec_valid && rec_addr_vld && rec_data_vld));

  // R8: a steady address and data in mode 5 produce nothing
  assert_mode5_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && mode_sel == 3'd5 && synced_q && last_mode_q == 3'd5 && !chg_addr && !chg_data)
      |=> !rec_valid);
endmodule

// File: rtl/bus_trace_abstractor.sv
module bus_trace_abstractor
  import trc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trace_en,
  input  logic [2:0]         mode_sel,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_data,
  input  logic [1:0]         bus_trans,
  input  logic               bus_write,
  input  logic [2:0]         bus_size,
  input  logic [2:0]         bus_burst,
  input  logic               bus_ready,
  input  logic [1:0]         bus_resp,
  output logic               rec_valid,
  output logic [2:0]         rec_mode,
  output logic               rec_addr_vld,
  output logic [ADDR_W-1:0]  rec_addr,
  output logic               rec_data_vld,
  output logic [DATA_W-1:0]  rec_data,
  output logic               rec_ctrl_vld,
  output logic [11:0]        rec_ctrl,
  output logic               rec_state_vld,
  output logic [2:0]         rec_state
);
  logic [CTRL_W-1:0]  cur_ctrl;
  logic [STATE_W-1:0] cur_state;
  logic               hold_en, chg_addr, chg_data, chg_ctrl, chg_state;

  assign cur_ctrl = {bus_write, bus_size, bus_burst, bus_trans, bus_ready, bus_resp};

  trc_state_encode i_enc (
    .trans (bus_trans),
    .ready (bus_ready),
    .resp  (bus_resp),
    .state (cur_state)
  );

  trc_field_track #(.W(ADDR_W)) i_trk_addr (
    .clk(clk), .rst_n(rst_n), .hold_en(hold_en), .cur(bus_addr), .changed(chg_addr));
  trc_field_track #(.W(DATA_W)) i_trk_data (
    .clk(clk), .rst_n(rst_n), .hold_en(hold_en), .cur(bus_data), .changed(chg_data));
  trc_field_track #(.W(CTRL_W)) i_trk_ctrl (
    .clk(clk), .rst_n(rst_n), .hold_en(hold_en), .cur(cur_ctrl), .changed(chg_ctrl));
  trc_field_track #(.W(STATE_W)) i_trk_state (
    .clk(clk), .rst_n(rst_n), .hold_en(hold_en), .cur(cur_state), .changed(chg_state));

  trc_record_former #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_form (
    .clk           (clk),
    .rst_n         (rst_n),
    .trace_en      (trace_en),
    .mode_sel      (mode_sel),
    .cur_addr      (bus_addr),
    .cur_data      (bus_data),
    .cur_ctrl      (cur_ctrl),
    .cur_state     (cur_state),
    .chg_addr      (chg_addr),
    .chg_data      (chg_data),
    .chg_ctrl      (chg_ctrl),
    .chg_state     (chg_state),
    .hold_en       (hold_en),
    .rec_valid     (rec_valid),
    .rec_mode      (rec_mode),
    .rec_addr_vld  (rec_addr_vld),
    .rec_addr      (rec_addr),
    .rec_data_vld  (rec_data_vld),
    .rec_data      (rec_data),
    .rec_ctrl_vld  (rec_ctrl_vld),
    .rec_ctrl      (rec_ctrl),
    .rec_state_vld (rec_state_vld),
    .rec_state     (rec_state)
  );
endmodule

// File: tb/test_bus_trace_abstractor.sv
`timescale 1ns/1ps
module test_bus_trace_abstractor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trace_en = 1'b0;
  logic [2:0]  mode_sel = 3'd0;
  logic [31:0] bus_addr = '0, bus_data = '0;
  logic [1:0]  bus_trans = '0, bus_resp = '0;
  logic        bus_write = 1'b0, bus_ready = 1'b1;
  logic [2:0]  bus_size = '0, bus_burst = '0;
  logic        rec_valid, rec_addr_vld, rec_data_vld, rec_ctrl_vld, rec_state_vld;
  logic [2:0]  rec_mode, rec_state;
  logic [31:0] rec_addr, rec_data;
  logic [11:0] rec_ctrl;

  always #2.5 clk = ~clk;

  bus_trace_abstractor i_bus_trace_abstractor (.*);

  typedef struct packed {
    logic v; logic [2:0] m; logic av; logic [31:0] a; logic dv; logic [31:0] d;
    logic cv; logic [11:0] c; logic sv; logic [2:0] s;
  } rec_t;

  rec_t        exp_q[$];
  string       tag_q[$];
  int          total = 0, bad = 0;
  bit          done = 0;
  logic [31:0] p_a, p_d;
  logic [11:0] p_c;
  logic [2:0]  p_s, last_m;
  bit          synced = 0;

  function automatic logic [2:0] enc(input logic [1:0] tr, input logic rdy, input logic [1:0] rs);
    if (rs != 0) return 3'd3 + {1'b0, rs};
    if (!rdy)    return 3'd3;
    if (tr == 0) return 3'd0;
    if (tr == 1) return 3'd1;
    return 3'd2;
  endfunction

  task automatic check_out();
    rec_t e, a;
    string t;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    a = {rec_valid, rec_mode, rec_addr_vld, rec_addr, rec_data_vld, rec_data,
         rec_ctrl_vld, rec_ctrl, rec_state_vld, rec_state};
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", t, a, e);
    end
  endtask

  task automatic drive(input logic en, input logic [2:0] m, input logic [31:0] a,
                       input logic [31:0] d, input logic [1:0] tr, input logic w,
                       input logic rdy, input logic [1:0] rs, input string tag);
    rec_t e;
    logic [11:0] c;
    logic [2:0]  s;
    bit act, frc, cyc, sc, ss;
    @(negedge clk);
    check_out();
    trace_en = en; mode_sel = m; bus_addr = a; bus_data = d; bus_trans = tr;
    bus_write = w; bus_ready = rdy; bus_resp = rs; bus_size = 3'd2; bus_burst = 3'd1;
    c = {w, 3'd2, 3'd1, tr, rdy, rs};
    s = enc(tr, rdy, rs);
    e = '0;
    act = en && m >= 1 && m <= 5;
    if (act) begin
      frc = !synced || m != last_m;
      cyc = (m == 1 || m == 3);
      sc  = (m == 1 || m == 2);
      ss  = (m == 3 || m == 4);
      e.av = frc || cyc || a != p_a;
      e.dv = frc || cyc || d != p_d;
      e.cv = sc && (frc || cyc || c != p_c);
      e.sv = ss && (frc || cyc || s != p_s);
      e.v  = e.av || e.dv || e.cv || e.sv;
      e.m  = e.v ? m : 3'd0;
      e.a  = e.av ? a : 32'd0;
      e.d  = e.dv ? d : 32'd0;
      e.c  = e.cv ? c : 12'd0;
      e.s  = e.sv ? s : 3'd0;
      p_a = a; p_d = d; p_c = c; p_s = s; synced = 1; last_m = m;
    end else begin
      p_a = '0; p_d = '0; p_c = '0; p_s = '0; synced = 0;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (rec_valid !== 0 || rec_mode !== 0 || rec_addr !== 0 || rec_ctrl !== 0) begin
      bad++;
      $display("FAIL R1 actual=%b/%h expected=0/0", rec_valid, rec_addr);
    end
    rst_n = 1'b1;
    drive(1'b0, 3'd1, 32'h10, 32'h1, 2'd2, 1'b1, 1'b1, 2'd0, "R1");
    // R4 / R12: cycle level with all signals, repeated values still recorded
    drive(1'b1, 3'd1, 32'h100, 32'hA, 2'd2, 1'b1, 1'b1, 2'd0, "R4 R12");
    drive(1'b1, 3'd1, 32'h100, 32'hA, 2'd2, 1'b1, 1'b1, 2'd0, "R4");
    drive(1'b1, 3'd1, 32'h104, 32'hB, 2'd3, 1'b0, 1'b1, 2'd0, "R4 R3");
    // R10: switch with no change gives a full record; R5 transaction level
    drive(1'b1, 3'd2, 32'h104, 32'hB, 2'd3, 1'b0, 1'b1, 2'd0, "R10");
    drive(1'b1, 3'd2, 32'h104, 32'hB, 2'd3, 1'b0, 1'b1, 2'd0, "R5 steady");
    drive(1'b1, 3'd2, 32'h104, 32'hC, 2'd3, 1'b0, 1'b1, 2'd0, "R5 data only");
    drive(1'b1, 3'd2, 32'h104, 32'hC, 2'd3, 1'b1, 1'b1, 2'd0, "R5 ctrl only");
    // R6 / R9: state codes at cycle level
    drive(1'b1, 3'd3, 32'h0, 32'h0, 2'd0, 1'b0, 1'b1, 2'd0, "R6 R9 idle");
    drive(1'b1, 3'd3, 32'h0, 32'h0, 2'd1, 1'b0, 1'b1, 2'd0, "R9 busy");
    drive(1'b1, 3'd3, 32'h8, 32'h0, 2'd2, 1'b0, 1'b1, 2'd0, "R9 normal");
    drive(1'b1, 3'd3, 32'h8, 32'h0, 2'd3, 1'b0, 1'b0, 2'd0, "R9 wait");
    drive(1'b1, 3'd3, 32'h8, 32'h0, 2'd3, 1'b0, 1'b0, 2'd1, "R9 error over wait");
    drive(1'b1, 3'd3, 32'h8, 32'h0, 2'd3, 1'b0, 1'b1, 2'd2, "R9 retry");
    drive(1'b1, 3'd3, 32'h8, 32'h0, 2'd3, 1'b0, 1'b1, 2'd3, "R9 split");
    // R7: state at transaction level
    drive(1'b1, 3'd4, 32'h8, 32'h0, 2'd2, 1'b0, 1'b1, 2'd0, "R7 R10");
    drive(1'b1, 3'd4, 32'h8, 32'h0, 2'd3, 1'b0, 1'b1, 2'd0, "R7 same state");
    drive(1'b1, 3'd4, 32'h8, 32'h0, 2'd3, 1'b0, 1'b0, 2'd0, "R7 state change");
    // R8: address and data only
    drive(1'b1, 3'd5, 32'h20, 32'h5, 2'd2, 1'b0, 1'b1, 2'd0, "R8 R10");
    drive(1'b1, 3'd5, 32'h20, 32'h5, 2'd1, 1'b1, 1'b0, 2'd1, "R8 ctrl ignored");
    drive(1'b1, 3'd5, 32'h24, 32'h5, 2'd1, 1'b1, 1'b0, 2'd1, "R8 addr");
    // R2: disable and re-enable with unchanged bus
    drive(1'b0, 3'd5, 32'h24, 32'h5, 2'd1, 1'b1, 1'b0, 2'd1, "R2 off");
    drive(1'b0, 3'd5, 32'h24, 32'h5, 2'd1, 1'b1, 1'b0, 2'd1, "R2 off");
    drive(1'b1, 3'd5, 32'h24, 32'h5, 2'd1, 1'b1, 1'b0, 2'd1, "R2 resync");
    // R11: unsupported codes
    drive(1'b1, 3'd6, 32'h24, 32'h5, 2'd1, 1'b1, 1'b0, 2'd1, "R11 mode6");
    drive(1'b1, 3'd0, 32'h30, 32'h6, 2'd1, 1'b1, 1'b0, 2'd1, "R11 mode0");
    drive(1'b1, 3'd5, 32'h30, 32'h6, 2'd1, 1'b1, 1'b0, 2'd1, "R11 resync");
    drive(1'b0, 3'd0, 32'h0, 32'h0, 2'd0, 1'b0, 1'b1, 2'd0, "R2 final");
    @(negedge clk);
    check_out();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule